// File: doc/BRIEF.md
# Clock-Forwarded Serial Word Receiver

This block takes a two-wire serial stream, made of a forwarded serial clock and a data line, and rebuilds the parallel word that the transmitting side shifted out. Both wires are first brought into the system clock domain through a chain of flip-flops of equal depth on each wire. The block then detects rising edges of the synchronized serial clock. Each detected rising edge samples one data bit, and a bit counter decodes that bit's slot in a holding register.

When the last bit of a word lands, the finished word moves to an output stage and is offered on a valid/ready stream. Back-pressure works as follows. While `m_valid_o` is high and `m_ready_i` is low, the offered word and the valid flag stay unchanged. If a further word completes in that state, the new word is discarded and the offered word is kept. A beat is accepted on any cycle in which both valid and ready are high. The serial clock must idle low. Raising the synchronous reset drops a partly received word, so a transfer that lost alignment can be restarted from bit zero.

Top module: `sclk_deser`

## Requirements
- R1: While `rst` is high on a clock edge, `m_valid_o` is low after that edge, and the bit counter returns to the first slot.
- R2: With `ORDER` set to LSB-first, the bit sampled on the k-th detected rising edge of a word (k counted from 0) appears at bit k of `m_data_o`.
- R3: With `ORDER` set to MSB-first, the bit sampled on the k-th detected rising edge appears at bit `WIDTH-1-k` of `m_data_o`.
- R4: Data is sampled only at a rising edge of the serial clock. Changes on the data line while the serial clock is high or low, and falling edges of the serial clock, do not alter the received word.
- R5: No word is offered until `WIDTH` rising edges have been received since reset or since the previous completed word.
- R6: While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o` stays high and `m_data_o` stays stable.
- R7: When `m_ready_i` is held high, each completed word produces exactly one cycle of `m_valid_o`.
- R8: A word that completes while a previous word is offered and not being accepted is discarded. Only the first word is ever delivered.
- R9: Raising `rst` in the middle of a word abandons the bits already received. The next word is assembled from slot 0.
- R10: With `SYNC_STAGES` stages, `m_valid_o` rises after the (`SYNC_STAGES`+2)-th system clock edge that follows the final rising edge on `ser_clk_i`, provided the output stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Forwarded serial clock, idles low |
| ser_dat_i | input | 1 | Serial data line |
| m_valid_o | output | 1 | Output word valid |
| m_ready_i | input | 1 | Downstream ready to accept |
| m_data_o | output | WIDTH | Rebuilt parallel word |

## Verification
The bench builds two instances that share one serial stream. Both use `WIDTH`=8 and two synchronizer stages. One instance is LSB-first and the other is MSB-first, so every value of an 8-bit word can be sent, and each delivered word is compared with the sent value and with its bit reversal. With this small word width, the stream also reaches the exact completion latency, the hold and drop behaviour under back-pressure, and a mid-word reset.

// File: rtl/sclk_deser_pkg.sv
package sclk_deser_pkg;
  typedef enum logic {
    ORDER_LSB_FIRST = 1'b0,
    ORDER_MSB_FIRST = 1'b1
  } bit_order_e;
endpackage

// File: rtl/sclk_deser_sync.sv
// Multi-stage synchronizer, applied bitwise to a small bundle.
module sclk_deser_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sclk_deser_edge.sv
// Rising-edge detector on a synchronized level.
module sclk_deser_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/sclk_deser_asm.sv
// Bit counter with slot decode; assembles one word and flags completion.
module sclk_deser_asm
  import sclk_deser_pkg::*;
#(
  parameter int         WIDTH = 8,
  parameter bit_order_e ORDER = ORDER_LSB_FIRST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic [WIDTH-1:0] word_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    slot;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_n;
  logic [WIDTH-1:0] sel;

  if (ORDER == ORDER_MSB_FIRST) begin : g_msb
    assign slot = LAST - cnt_q;
  end else begin : g_lsb
    assign slot = cnt_q;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_slot
    assign sel[i]    = (slot == CW'(i));
    assign hold_n[i] = sel[i] ? bit_i : hold_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (rise_i) begin
        hold_q <= hold_n;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
          word_o <= hold_n;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sclk_deser_out.sv
// Single-entry output stage; a word arriving while full and stalled is dropped.
module sclk_deser_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [WIDTH-1:0] m_data_o
);
  logic can_load;
  assign can_load = ~m_valid_o | m_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
    end else if (can_load) begin
      m_valid_o <= done_i;
      if (done_i) m_data_o <= word_i;
    end
  end
endmodule

// File: rtl/sclk_deser.sv
module sclk_deser
  import sclk_deser_pkg::*;
#(
  parameter int         WIDTH       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter bit_order_e ORDER       = ORDER_LSB_FIRST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [WIDTH-1:0] m_data_o
);
  logic [1:0]       sync_q;
  logic             ser_rise;
  logic             asm_done;
  logic [WIDTH-1:0] asm_word;

  sclk_deser_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({ser_clk_i, ser_dat_i}),
    .q_o(sync_q)
  );

  sclk_deser_edge u_edge (
    .clk(clk), .rst(rst),
    .level_i(sync_q[1]),
    .rise_o(ser_rise)
  );

  sclk_deser_asm #(.WIDTH(WIDTH), .ORDER(ORDER)) u_asm (
    .clk(clk), .rst(rst),
    .rise_i(ser_rise), .bit_i(sync_q[0]),
    .done_o(asm_done), .word_o(asm_word)
  );

  sclk_deser_out #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst(rst),
    .done_i(asm_done), .word_i(asm_word),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i),
    .m_data_o(m_data_o)
  );
endmodule

// File: rtl/sclk_deser_chk.sv
module sclk_deser_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             m_valid,
  input logic             m_ready,
  input logic [WIDTH-1:0] m_data,
  input logic             seen_rise,
  input logic             asm_done
);
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid);

  p_keep_data_r8: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> $stable(m_data));

  p_done_after_rise_r5: assert property (@(posedge clk) disable iff (rst)
    asm_done |-> $past(seen_rise));

  p_single_beat_r7: assert property (@(posedge clk) disable iff (rst)
    m_valid && m_ready && !asm_done |=> !m_valid);
endmodule

bind sclk_deser sclk_deser_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .m_valid(m_valid_o), .m_ready(m_ready_i),
  .m_data(m_data_o), .seen_rise(ser_rise), .asm_done(asm_done)
);

// File: tb/sclk_deser_tb_top.sv
module sclk_deser_tb_top;
  import sclk_deser_pkg::*;
  localparam int W = 8;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic ready = 1'b1;
  logic v_lsb, v_msb;
  logic [W-1:0] d_lsb, d_msb;

  int compared = 0;
  int mismatched = 0;
  int hs_cnt = 0;
  logic [W-1:0] hs_lsb = '0;
  logic [W-1:0] hs_msb = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  sclk_deser #(.WIDTH(W), .SYNC_STAGES(2), .ORDER(ORDER_LSB_FIRST)) dut_i (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .m_valid_o(v_lsb), .m_ready_i(ready), .m_data_o(d_lsb));

  sclk_deser #(.WIDTH(W), .SYNC_STAGES(2), .ORDER(ORDER_MSB_FIRST)) dut_msb_i (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .m_valid_o(v_msb), .m_ready_i(ready), .m_data_o(d_msb));

  always @(negedge clk) begin
    if (v_lsb && ready) begin
      hs_cnt <= hs_cnt + 1;
      hs_lsb <= d_lsb;
    end
    if (v_msb && ready) hs_msb <= d_msb;
  end

  function automatic logic [W-1:0] rev(input logic [W-1:0] x);
    for (int i = 0; i < W; i++) rev[i] = x[W-1-i];
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit; optional data wiggles away from the rising edge
  task automatic ser_bit(input logic b, input bit wiggle);
    ser_dat = b;
    wait_cyc(HALF);
    ser_clk = 1'b1;
    wait_cyc(2);
    if (wiggle) ser_dat = ~b;
    wait_cyc(HALF - 2);
    ser_clk = 1'b0;
    if (wiggle) begin
      wait_cyc(1);
      ser_dat = b;
    end
  endtask

  task automatic send_word(input logic [W-1:0] v, input bit wiggle);
    for (int i = 0; i < W; i++) ser_bit(v[i], wiggle);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    wait_cyc(1);
  endtask

  initial begin
    int base;
    logic [W-1:0] a, b;
    wait_cyc(3);
    // R1: reset state
    check("R1 lsb valid", v_lsb, 0);
    check("R1 msb valid", v_msb, 0);
    rst = 1'b0;
    wait_cyc(2);

    // R2/R3/R4/R7: full sweep of all word values
    for (int v = 0; v < (1 << W); v++) begin
      base = hs_cnt;
      send_word(W'(v), v[0]);
      wait_cyc(8);
      check("R7 one beat", hs_cnt - base, 1);
      check(v[0] ? "R4 R2 lsb-first" : "R2 lsb-first", hs_lsb, v);
      check(v[0] ? "R4 R3 msb-first" : "R3 msb-first", hs_msb, rev(W'(v)));
    end

    // R5 and R10: hold back the final bit, then time it
    a = 8'hA5;
    base = hs_cnt;
    for (int i = 0; i < W - 1; i++) ser_bit(a[i], 1'b0);
    wait_cyc(12);
    check("R5 no early valid", v_lsb, 0);
    check("R5 no early beat", hs_cnt - base, 0);
    ser_dat = a[W-1];
    wait_cyc(HALF);
    ser_clk = 1'b1;
    wait_cyc(3);
    check("R10 not yet valid", v_lsb, 0);
    wait_cyc(1);
    check("R10 valid at stages+2", v_lsb, 1);
    check("R10 data", d_lsb, a);
    wait_cyc(1);
    check("R7 pulse ends", v_lsb, 0);
    ser_clk = 1'b0;
    wait_cyc(HALF);

    // R6/R8: back-pressure hold and drop
    ready = 1'b0;
    a = 8'h3C;
    b = 8'hC3;
    base = hs_cnt;
    send_word(a, 1'b0);
    wait_cyc(8);
    check("R6 valid held", v_lsb, 1);
    check("R6 data held", d_lsb, a);
    send_word(b, 1'b0);
    wait_cyc(8);
    check("R6 still valid", v_lsb, 1);
    check("R8 first word kept", d_lsb, a);
    ready = 1'b1;
    wait_cyc(10);
    check("R8 single delivery", hs_cnt - base, 1);
    check("R8 delivered word", hs_lsb, a);
    check("R8 nothing pending", v_lsb, 0);

    // R9: abandon a partial word with reset
    for (int i = 0; i < 3; i++) ser_bit(1'b1, 1'b0);
    do_reset();
    check("R1 valid after reset", v_lsb, 0);
    a = 8'h81;
    base = hs_cnt;
    send_word(a, 1'b0);
    wait_cyc(8);
    check("R9 one beat", hs_cnt - base, 1);
    check("R9 realigned lsb", hs_lsb, a);
    check("R9 realigned msb", hs_msb, rev(a));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule